// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block merges three reset requests into a single active-low reset line. The requests are an undervoltage flag coming from an analog comparator, a push-button manual reset that is active low and idles high, and a one-cycle fault pulse from a watchdog. The undervoltage flag and the manual reset arrive asynchronously, so each passes through a two-flop synchronizer. The manual reset then goes through a glitch filter that accepts a low level only after it has held for a set number of clock cycles.

Whenever any request is active, the reset is asserted and a hold counter is reloaded. Once every request has cleared, the counter counts down in ticks of an external prescaled time base. Reset is released on the tick that takes the count to zero. A 2-bit option code selects one of four hold lengths, each given as a tick-count parameter. After power-on reset the block asserts the line and runs a full hold before releasing it.

A status output tells the watchdog when reset is asserted, so the watchdog can stay cleared during that time. The block also produces a drive-enable flag so that a pad can behave as push-pull or as open-drain.

Top module: `rst_pulse_gen`

## Requirements
- R1: A high undervoltage input, a filtered manual-reset low, or a fault pulse drives `rst_out_n` low within four clock cycles.
- R2: Once all requests are clear, `rst_out_n` stays low through N-1 ticks and goes high on the N-th tick. N is HOLD_T0, HOLD_T1, HOLD_T2 or HOLD_T3 for `hold_sel` codes 0, 1, 2 and 3.
- R3: A new request during a hold restarts the full N-tick hold once that request clears.
- R4: While `rst_n` is low, `rst_out_n` is low. After `rst_n` is released, a full N-tick hold runs before release.
- R5: A manual-reset low held for fewer than FILT_CYCLES clock samples has no effect on `rst_out_n`. A low held for FILT_CYCLES samples asserts reset.
- R6: A manual-reset input held high gives no request. Its synchronizer resets to the high (idle) level.
- R7: With `od_mode` set to 1, `rst_drive_en` is 1 only while reset is asserted. With `od_mode` set to 0, `rst_drive_en` is always 1.
- R8: `rst_active` is 1 exactly when `rst_out_n` is 0.
- R9: Ticks that arrive while any request is active do not shorten the later hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick | input | 1 | One-cycle time-base tick from a prescaler |
| uv_async | input | 1 | Undervoltage flag, high means the supply is below threshold, asynchronous |
| mr_n_async | input | 1 | Manual reset, active low, asynchronous |
| wd_fault | input | 1 | One-cycle watchdog fault pulse, synchronous to clk |
| hold_sel | input | 2 | Hold-length option code |
| od_mode | input | 1 | 1 selects open-drain, 0 selects push-pull |
| rst_out_n | output | 1 | Combined reset, active low |
| rst_drive_en | output | 1 | Pad drive enable |
| rst_active | output | 1 | Reset-asserted status for the watchdog |

## Verification
The bench builds the block with hold lengths of 2, 3, 5 and 8 ticks and a filter length of 4 cycles. With these values, every option code can be swept against every request source, tick by tick, up to the exact release tick. The manual-reset filter can also be tested at FILT_CYCLES-1 and at FILT_CYCLES samples within a few cycles.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    HOLD_OPT0 = 2'd0,
    HOLD_OPT1 = 2'd1,
    HOLD_OPT2 = 2'd2,
    HOLD_OPT3 = 2'd3
  } hold_opt_e;
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rpg_glitch_filter.sv
module rpg_glitch_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_req
);
  localparam int FW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

  logic [FW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      mr_req  <= 1'b0;
    end else if (mr_n_s) begin
      low_cnt <= '0;
      mr_req  <= 1'b0;
    end else if (low_cnt == LAST) begin
      mr_req  <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // R5: a request may only appear after the synchronized input was low
  a_r5_req_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_req) |-> $past(!mr_n_s));
  // R6: a high input clears the request on the next edge
  a_r6_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mr_n_s |=> !mr_req);
endmodule

// File: rtl/rpg_hold_timer.sv
module rpg_hold_timer
  import rpg_pkg::*;
#(
  parameter int HOLD_T0 = 14,
  parameter int HOLD_T1 = 280,
  parameter int HOLD_T2 = 2000,
  parameter int HOLD_T3 = 16000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic      tick,
  input  hold_opt_e sel,
  output logic      busy
);
  localparam int HMAX01 = (HOLD_T0 > HOLD_T1) ? HOLD_T0 : HOLD_T1;
  localparam int HMAX23 = (HOLD_T2 > HOLD_T3) ? HOLD_T2 : HOLD_T3;
  localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
  localparam int CW     = $clog2(HMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  always_comb begin
    unique case (sel)
      HOLD_OPT0: reload = CW'(HOLD_T0);
      HOLD_OPT1: reload = CW'(HOLD_T1);
      HOLD_OPT2: reload = CW'(HOLD_T2);
      default:   reload = CW'(HOLD_T3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (load) begin
      cnt  <= reload;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (cnt <= CW'(1)) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt  <= cnt - 1'b1;
      end
    end
  end

  // R9: without a tick the count holds while waiting
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !tick) |=> ($stable(cnt) && busy));
  // R3: a load always leaves the timer busy
  a_r3_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  // R2: the count never exceeds the largest option
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HMAX));
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rpg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4,
  parameter int HOLD_T0     = 14,
  parameter int HOLD_T1     = 280,
  parameter int HOLD_T2     = 2000,
  parameter int HOLD_T3     = 16000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       uv_async,
  input  logic       mr_n_async,
  input  logic       wd_fault,
  input  logic [1:0] hold_sel,
  input  logic       od_mode,
  output logic       rst_out_n,
  output logic       rst_drive_en,
  output logic       rst_active
);
  logic uv_s, mr_n_s, mr_req, por_q, req_any, busy;

  rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_uv_sync (
    .clk(clk), .rst_n(rst_n), .d_async(uv_async), .q(uv_s));

  rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst_n(rst_n), .d_async(mr_n_async), .q(mr_n_s));

  rpg_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .mr_n_s(mr_n_s), .mr_req(mr_req));

  // one-cycle power-on request so the first hold uses the live option code
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) por_q <= 1'b1;
    else        por_q <= 1'b0;

  assign req_any = por_q | uv_s | mr_req | wd_fault;

  rpg_hold_timer #(
    .HOLD_T0(HOLD_T0), .HOLD_T1(HOLD_T1),
    .HOLD_T2(HOLD_T2), .HOLD_T3(HOLD_T3)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load(req_any), .tick(tick),
    .sel(hold_opt_e'(hold_sel)), .busy(busy));

  assign rst_out_n    = ~busy;
  assign rst_active   = busy;
  assign rst_drive_en = od_mode ? busy : 1'b1;

  // R1: any active request holds the output low on the next edge
  a_r1_req_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |=> !rst_out_n);
  // R2: release only follows a tick with no request pending
  a_r2_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(tick) && !$past(req_any)));
  // R7: open-drain mode never drives a released line
  a_r7_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && rst_out_n) |-> !rst_drive_en);
endmodule

// File: tb/rst_pulse_gen_bench.sv
module rst_pulse_gen_bench;
  localparam int FILT = 4;
  localparam int T0 = 2, T1 = 3, T2 = 5, T3 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, uv_async = 1'b0, mr_n_async = 1'b1;
  logic wd_fault = 1'b0, od_mode = 1'b0;
  logic [1:0] hold_sel = 2'd0;
  logic rst_out_n, rst_drive_en, rst_active;
  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  rst_pulse_gen #(.SYNC_STAGES(2), .FILT_CYCLES(FILT),
    .HOLD_T0(T0), .HOLD_T1(T1), .HOLD_T2(T2), .HOLD_T3(T3)) u_rst_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_async(uv_async),
    .mr_n_async(mr_n_async), .wd_fault(wd_fault), .hold_sel(hold_sel),
    .od_mode(od_mode), .rst_out_n(rst_out_n), .rst_drive_en(rst_drive_en),
    .rst_active(rst_active));

  function automatic int hold_of(input int s);
    return (s == 0) ? T0 : (s == 1) ? T1 : (s == 2) ? T2 : T3;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_once();
    tick = 1'b1; step(1); tick = 1'b0;
  endtask

  // R2: low through n-1 ticks, high after n-th; R8 status tracks it
  task automatic hold_check(input int n, input string tag);
    for (int i = 1; i < n; i++) begin
      tick_once();
      chk({tag, " R2 still held"}, rst_out_n, 1'b0);
    end
    tick_once();
    chk({tag, " R2 released"}, rst_out_n, 1'b1);
    chk({tag, " R8 status idle"}, rst_active, 1'b0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    // R4 power-on
    hold_sel = 2'd1;
    step(3);
    chk("R4 low in reset", rst_out_n, 1'b0);
    chk("R8 active in reset", rst_active, 1'b1);
    rst_n = 1'b1;
    step(3);
    chk("R4 held after reset", rst_out_n, 1'b0);
    hold_check(T1, "R4");

    // R6 idle-high manual input gives no request
    step(8);
    chk("R6 no request", rst_out_n, 1'b1);

    // sweep every option code against every source
    for (int s = 0; s < 4; s++) begin
      hold_sel = 2'(s);
      for (int src = 0; src < 3; src++) begin
        if (src == 0) uv_async = 1'b1;
        else if (src == 1) mr_n_async = 1'b0;
        else begin wd_fault = 1'b1; step(1); wd_fault = 1'b0; end
        step(FILT + 3);
        chk("R1 asserted", rst_out_n, 1'b0);
        chk("R8 active", rst_active, 1'b1);
        uv_async = 1'b0; mr_n_async = 1'b1;
        step(5);
        hold_check(hold_of(s), "R2 sweep");
      end
    end

    // R9 ticks during an active request are ignored
    hold_sel = 2'd2;
    uv_async = 1'b1; step(4);
    for (int i = 0; i < 12; i++) tick_once();
    chk("R9 held during request", rst_out_n, 1'b0);
    uv_async = 1'b0; step(5);
    hold_check(T2, "R9");

    // R3 restart in mid-hold
    hold_sel = 2'd3;
    wd_fault = 1'b1; step(1); wd_fault = 1'b0; step(3);
    for (int i = 0; i < T3 - 1; i++) tick_once();
    chk("R3 pre-restart held", rst_out_n, 1'b0);
    wd_fault = 1'b1; step(1); wd_fault = 1'b0; step(3);
    hold_check(T3, "R3");

    // R5 glitch filter: FILT-1 samples ignored, FILT samples accepted
    hold_sel = 2'd0;
    mr_n_async = 1'b0; step(FILT - 1); mr_n_async = 1'b1;
    step(8);
    chk("R5 short low ignored", rst_out_n, 1'b1);
    mr_n_async = 1'b0; step(FILT); mr_n_async = 1'b1;
    step(4);
    chk("R5 full low accepted", rst_out_n, 1'b0);
    step(3);
    hold_check(T0, "R5");

    // R7 drive enable in both modes
    od_mode = 1'b1; step(1);
    chk("R7 od released", rst_drive_en, 1'b0);
    uv_async = 1'b1; step(4);
    chk("R7 od asserted", rst_drive_en, 1'b1);
    od_mode = 1'b0; step(1);
    chk("R7 pp asserted", rst_drive_en, 1'b1);
    uv_async = 1'b0; step(5);
    hold_check(T0, "R7");
    chk("R7 pp released", rst_drive_en, 1'b1);

    report();
  end
endmodule